// File: doc/BRIEF.md
# Reset and Startup Lockout Sequencer

This controller brings an audio output device up after a reset. An external active-low reset pin, or a one-cycle soft-reset request, starts a fixed initialization window. During that window the internal memories are being loaded with their defaults. Accesses to the coefficient buffers and requests to power up blocks are refused, and every output stage stays off. When the window closes, the sequencer raises `ready` and from then on lets those requests through.

Once `ready` is high, a separate gate times the PLL. After the PLL is enabled, clocks are reported valid only after a settling period has run uninterrupted. Turning the PLL off removes the valid indication at once.

Each of the four output stages has an overcurrent latch that turns its enable off. A latch is cleared only by its own clear bit. Both speaker halves share one clear bit. Clearing a latch does not restart initialization or touch the clock state, so the rest of the configuration stays as it was.

Top module: `boot_sequencer`

## Requirements
- R1: A low level on `rstPinN` forces `ready`, `clocksValid`, `coefGrant`, `pwrUpGrant` and all of `stageEn` to 0 at once, without waiting for a clock edge. A low pulse much shorter than one clock period has the same effect.
- R2: After `rstPinN` returns high, `ready` rises at the (INIT_CYCLES+2)-th rising clock edge, counted from the first edge that finds the pin high. That count is two synchronizer edges plus INIT_CYCLES counting edges.
- R3: A `softRst` sampled high at an edge drops `ready` and `clocksValid` after that edge and clears every overcurrent latch. `ready` rises again INIT_CYCLES edges later.
- R4: `coefGrant` equals `coefReq` while `ready` is 1 and is 0 while `ready` is 0.
- R5: `pwrUpGrant` equals `pwrUpReq` while `ready` is 1 and is 0 while `ready` is 0.
- R6: `clocksValid` rises at the SETTLE_CYCLES-th consecutive edge at which both `pllEnable` and `ready` are high.
- R7: `clocksValid` is 0 in the same cycle that `pllEnable` is 0. The next enable restarts the full settling count.
- R8: An `ocFlag` bit sampled high sets its stage's latch, and the matching `stageEn` bit is 0 from the next edge on, until the latch is cleared. The bit order in `ocFlag` and `stageEn` is: 0 = left headphone, 1 = right headphone, 2 = speaker plus, 3 = speaker minus.
- R9: `hpLeftClr` clears only latch 0 and `hpRightClr` clears only latch 1. `spkClr` clears latches 2 and 3 together.
- R10: A clear bit sampled while the stage's `ocFlag` is still high leaves that latch set.
- R11: Clearing latches leaves `ready` and `clocksValid` unchanged.
- R12: Each `stageEn` bit is 0 while `ready` is 0, even when its latch is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstPinN | input | 1 | External reset pin, active low, asynchronous |
| softRst | input | 1 | One-cycle software reset request |
| pllEnable | input | 1 | PLL power-up enable |
| coefReq | input | 1 | Coefficient buffer access request |
| pwrUpReq | input | 1 | Block power-up request |
| ocFlag | input | 4 | Overcurrent detectors, one per stage |
| hpLeftClr | input | 1 | Clear bit for left headphone latch |
| hpRightClr | input | 1 | Clear bit for right headphone latch |
| spkClr | input | 1 | Clear bit for both speaker latches |
| ready | output | 1 | Initialization complete |
| clocksValid | output | 1 | PLL settled and enabled |
| coefGrant | output | 1 | Coefficient access granted |
| pwrUpGrant | output | 1 | Power-up request accepted |
| stageEn | output | 4 | Output stage enables |

## Verification
The bench builds the block with INIT_CYCLES = 20 and SETTLE_CYCLES = 30, in place of the real millisecond-scale counts. With these values the exact edge at which `ready` and `clocksValid` rise can be checked, one edge early and on the edge. This applies after a pin release, after a soft reset, after a sub-cycle pin glitch, and after a PLL restart. The short windows leave room in one run to trip all four latches, clear them in the mixed single and paired patterns, and try a clear against a flag that is still active.

// File: rtl/boot_seq_pkg.sv
package boot_seq_pkg;
  localparam int NUM_STAGES = 4;
  localparam int STG_HP_L   = 0;
  localparam int STG_HP_R   = 1;
  localparam int STG_SPK_P  = 2;
  localparam int STG_SPK_M  = 3;

  typedef enum logic [0:0] {ST_INIT, ST_RUN} seqState_t;

  typedef struct packed {
    logic restart;
    logic run;
  } seqStrobe_t;
endpackage

// File: rtl/boot_rst_sync.sv
module boot_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic pinN,
  output logic rstN
);
  logic [STAGES-1:0] syncQ;

  always_ff @(posedge clk or negedge pinN) begin
    if (!pinN) syncQ <= '0;
    else       syncQ <= {syncQ[STAGES-2:0], 1'b1};
  end

  assign rstN = syncQ[STAGES-1];
endmodule

// File: rtl/boot_seq_ctrl.sv
module boot_seq_ctrl
  import boot_seq_pkg::*;
#(
  parameter int INIT_CYCLES = 24000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       softRst,
  output seqStrobe_t strobe
);
  localparam int CW = $clog2(INIT_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(INIT_CYCLES - 1);

  seqState_t state;
  logic [CW-1:0] initCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_INIT;
      initCnt <= '0;
    end else if (softRst) begin
      state   <= ST_INIT;
      initCnt <= '0;
    end else if (state == ST_INIT) begin
      if (initCnt == LAST) begin
        state   <= ST_RUN;
        initCnt <= '0;
      end else begin
        initCnt <= initCnt + 1'b1;
      end
    end
  end

  always_comb begin
    strobe.restart = softRst;
    strobe.run     = (state == ST_RUN);
  end
endmodule

// File: rtl/boot_seq_dp.sv
module boot_seq_dp
  import boot_seq_pkg::*;
#(
  parameter int SETTLE_CYCLES = 240000,
  parameter int STAGES        = NUM_STAGES
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic              pllEnable,
  input  logic              coefReq,
  input  logic              pwrUpReq,
  input  logic [STAGES-1:0] ocFlag,
  input  logic [STAGES-1:0] stageClr,
  output logic              clocksValid,
  output logic              coefGrant,
  output logic              pwrUpGrant,
  output logic [STAGES-1:0] stageEn
);
  localparam int SW = $clog2(SETTLE_CYCLES + 1);
  localparam logic [SW-1:0] SLAST = SW'(SETTLE_CYCLES - 1);

  logic [SW-1:0] settleCnt;
  logic          settled;
  logic [STAGES-1:0] ocLatch;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      settleCnt <= '0;
      settled   <= 1'b0;
    end else if (strobe.restart || !pllEnable) begin
      settleCnt <= '0;
      settled   <= 1'b0;
    end else if (strobe.run && !settled) begin
      if (settleCnt == SLAST) settled <= 1'b1;
      else                    settleCnt <= settleCnt + 1'b1;
    end
  end

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)               ocLatch[g] <= 1'b0;
      else if (strobe.restart) ocLatch[g] <= 1'b0;
      else                     ocLatch[g] <= ocFlag[g] | (ocLatch[g] & ~stageClr[g]);
    end
    assign stageEn[g] = strobe.run & ~ocLatch[g];
  end

  assign clocksValid = settled & pllEnable;
  assign coefGrant   = coefReq & strobe.run;
  assign pwrUpGrant  = pwrUpReq & strobe.run;
endmodule

// File: rtl/boot_sequencer.sv
module boot_sequencer
  import boot_seq_pkg::*;
#(
  parameter int INIT_CYCLES   = 24000,
  parameter int SETTLE_CYCLES = 240000
) (
  input  logic       clk,
  input  logic       rstPinN,
  input  logic       softRst,
  input  logic       pllEnable,
  input  logic       coefReq,
  input  logic       pwrUpReq,
  input  logic [3:0] ocFlag,
  input  logic       hpLeftClr,
  input  logic       hpRightClr,
  input  logic       spkClr,
  output logic       ready,
  output logic       clocksValid,
  output logic       coefGrant,
  output logic       pwrUpGrant,
  output logic [3:0] stageEn
);
  logic sysRstN;
  seqStrobe_t strobe;
  logic [NUM_STAGES-1:0] stageClr;

  always_comb begin
    stageClr            = '0;
    stageClr[STG_HP_L]  = hpLeftClr;
    stageClr[STG_HP_R]  = hpRightClr;
    stageClr[STG_SPK_P] = spkClr;
    stageClr[STG_SPK_M] = spkClr;
  end

  boot_rst_sync #(.STAGES(2)) u_sync (
    .clk  (clk),
    .pinN (rstPinN),
    .rstN (sysRstN)
  );

  boot_seq_ctrl #(.INIT_CYCLES(INIT_CYCLES)) u_ctrl (
    .clk     (clk),
    .rstN    (sysRstN),
    .softRst (softRst),
    .strobe  (strobe)
  );

  boot_seq_dp #(.SETTLE_CYCLES(SETTLE_CYCLES), .STAGES(NUM_STAGES)) u_dp (
    .clk         (clk),
    .rstN        (sysRstN),
    .strobe      (strobe),
    .pllEnable   (pllEnable),
    .coefReq     (coefReq),
    .pwrUpReq    (pwrUpReq),
    .ocFlag      (ocFlag),
    .stageClr    (stageClr),
    .clocksValid (clocksValid),
    .coefGrant   (coefGrant),
    .pwrUpGrant  (pwrUpGrant),
    .stageEn     (stageEn)
  );

  assign ready = strobe.run;
endmodule

// File: rtl/boot_seq_chk.sv
module boot_seq_chk (
  input logic       clk,
  input logic       sysRstN,
  input logic       rstPinN,
  input logic       softRst,
  input logic       pllEnable,
  input logic [3:0] ocFlag,
  input logic       hpLeftClr,
  input logic       hpRightClr,
  input logic       spkClr,
  input logic       ready,
  input logic       clocksValid,
  input logic       coefGrant,
  input logic       pwrUpGrant,
  input logic [3:0] stageEn
);
  logic [3:0] clrVec;
  assign clrVec = {spkClr, spkClr, hpRightClr, hpLeftClr};

  p_coef_blocked_r4: assert property (@(posedge clk) disable iff (!sysRstN)
    !ready |-> !coefGrant);

  p_pwrup_blocked_r5: assert property (@(posedge clk) disable iff (!sysRstN)
    !ready |-> !pwrUpGrant);

  p_settle_rise_r6: assert property (@(posedge clk) disable iff (!sysRstN)
    $rose(clocksValid) |-> $past(pllEnable) && $past(ready));

  p_pll_off_r7: assert property (@(posedge clk) disable iff (!sysRstN)
    !pllEnable |-> !clocksValid);

  p_soft_restart_r3: assert property (@(posedge clk) disable iff (!sysRstN || !rstPinN)
    softRst |=> !ready && !clocksValid);

  p_stage_gated_r12: assert property (@(posedge clk) disable iff (!sysRstN)
    !ready |-> stageEn == 4'b0000);

  p_clear_keeps_ready_r11: assert property (@(posedge clk) disable iff (!sysRstN || !rstPinN)
    (ready && !softRst && (hpLeftClr || hpRightClr || spkClr)) |=> ready);

  for (genvar g = 0; g < 4; g++) begin : g_chk
    p_trip_r8: assert property (@(posedge clk) disable iff (!sysRstN || !rstPinN)
      ocFlag[g] |=> !stageEn[g]);

    p_hold_r8: assert property (@(posedge clk) disable iff (!sysRstN || !rstPinN)
      (ready && !stageEn[g] && !clrVec[g] && !softRst) |=> !stageEn[g]);

    p_clear_blocked_r10: assert property (@(posedge clk) disable iff (!sysRstN || !rstPinN)
      (clrVec[g] && ocFlag[g]) |=> !stageEn[g]);
  end
endmodule

bind boot_sequencer boot_seq_chk u_chk (
  .clk         (clk),
  .sysRstN     (sysRstN),
  .rstPinN     (rstPinN),
  .softRst     (softRst),
  .pllEnable   (pllEnable),
  .ocFlag      (ocFlag),
  .hpLeftClr   (hpLeftClr),
  .hpRightClr  (hpRightClr),
  .spkClr      (spkClr),
  .ready       (ready),
  .clocksValid (clocksValid),
  .coefGrant   (coefGrant),
  .pwrUpGrant  (pwrUpGrant),
  .stageEn     (stageEn)
);

// File: tb/tb_boot_sequencer.sv
module tb_boot_sequencer;
  localparam int CLK_PERIOD = 10;
  localparam int INIT_C     = 20;
  localparam int SETTLE_C   = 30;

  logic clk = 1'b0;
  logic rstPinN = 1'b0;
  logic softRst = 1'b0, pllEnable = 1'b0, coefReq = 1'b1, pwrUpReq = 1'b1;
  logic [3:0] ocFlag = 4'b0000;
  logic hpLeftClr = 1'b0, hpRightClr = 1'b0, spkClr = 1'b0;
  logic ready, clocksValid, coefGrant, pwrUpGrant;
  logic [3:0] stageEn;

  always #(CLK_PERIOD/2) clk = ~clk;

  boot_sequencer #(.INIT_CYCLES(INIT_C), .SETTLE_CYCLES(SETTLE_C)) dut (
    .clk(clk), .rstPinN(rstPinN), .softRst(softRst), .pllEnable(pllEnable),
    .coefReq(coefReq), .pwrUpReq(pwrUpReq), .ocFlag(ocFlag),
    .hpLeftClr(hpLeftClr), .hpRightClr(hpRightClr), .spkClr(spkClr),
    .ready(ready), .clocksValid(clocksValid), .coefGrant(coefGrant),
    .pwrUpGrant(pwrUpGrant), .stageEn(stageEn)
  );

  typedef struct {
    string      req;
    logic [7:0] exp;
  } item_t;

  item_t sbQ[$];
  int vecCnt = 0;
  int missCnt = 0;
  bit done = 1'b0;

  // Monitor: compares queued expectations against outputs away from the edge
  always @(negedge clk) begin
    while (sbQ.size() > 0) begin
      item_t it;
      logic [7:0] obs;
      it  = sbQ.pop_front();
      obs = {ready, clocksValid, coefGrant, pwrUpGrant, stageEn};
      vecCnt++;
      if (obs !== it.exp) begin
        missCnt++;
        $display("FAIL %s: got rdy/cv/cg/pg/en=%b expected %b", it.req, obs, it.exp);
      end
    end
  end

  function automatic logic [7:0] mk(logic r, logic cv, logic cg, logic pg, logic [3:0] en);
    return {r, cv, cg, pg, en};
  endfunction

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic expectOut(string req, logic [7:0] e);
    item_t it;
    it.req = req;
    it.exp = e;
    sbQ.push_back(it);
    @(negedge clk);
    #1;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, missCnt);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      missCnt++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    // R1 / R12: held in reset
    tick(3);
    expectOut("R1 pin held low", mk(0, 0, 0, 0, 4'b0000));

    // R2: release and exact ready edge
    tick(1);
    rstPinN = 1'b1;
    tick(INIT_C + 1);
    expectOut("R2 one edge before ready", mk(0, 0, 0, 0, 4'b0000));
    tick(1);
    expectOut("R2 ready edge, R4 R5 grants", mk(1, 0, 1, 1, 4'b1111));

    // R4, R5: requests low
    coefReq = 1'b0;
    expectOut("R4 no coef request", mk(1, 0, 0, 1, 4'b1111));
    pwrUpReq = 1'b0;
    coefReq = 1'b1;
    expectOut("R5 no power-up request", mk(1, 0, 1, 0, 4'b1111));
    pwrUpReq = 1'b1;

    // R6: settling gate
    tick(1);
    pllEnable = 1'b1;
    tick(SETTLE_C - 1);
    expectOut("R6 one edge before valid", mk(1, 0, 1, 1, 4'b1111));
    tick(1);
    expectOut("R6 clocks valid", mk(1, 1, 1, 1, 4'b1111));

    // R7: drop and restart
    pllEnable = 1'b0;
    expectOut("R7 immediate drop", mk(1, 0, 1, 1, 4'b1111));
    tick(1);
    pllEnable = 1'b1;
    tick(SETTLE_C - 1);
    expectOut("R7 restart not yet valid", mk(1, 0, 1, 1, 4'b1111));
    tick(1);
    expectOut("R7 restart valid", mk(1, 1, 1, 1, 4'b1111));

    // R8: trip each stage one by one
    tick(1); ocFlag = 4'b0001; tick(1); ocFlag = 4'b0000;
    expectOut("R8 left headphone trip", mk(1, 1, 1, 1, 4'b1110));
    tick(5);
    expectOut("R8 latch holds", mk(1, 1, 1, 1, 4'b1110));
    tick(1); ocFlag = 4'b0100; tick(1); ocFlag = 4'b0000;
    expectOut("R8 speaker plus trip", mk(1, 1, 1, 1, 4'b1010));
    tick(1); ocFlag = 4'b1010; tick(1); ocFlag = 4'b0000;
    expectOut("R8 right hp and speaker minus trip", mk(1, 1, 1, 1, 4'b0000));

    // R9, R11: selective clears
    tick(1); hpRightClr = 1'b1; tick(1); hpRightClr = 1'b0;
    expectOut("R9 R11 right headphone clear", mk(1, 1, 1, 1, 4'b0010));
    tick(1); spkClr = 1'b1; tick(1); spkClr = 1'b0;
    expectOut("R9 R11 speaker pair clear", mk(1, 1, 1, 1, 4'b1110));

    // R10: clear while flag active
    tick(1); ocFlag = 4'b0001; hpLeftClr = 1'b1; tick(1); hpLeftClr = 1'b0;
    expectOut("R10 clear refused under flag", mk(1, 1, 1, 1, 4'b1110));
    ocFlag = 4'b0000;
    tick(2);
    expectOut("R10 still latched after flag", mk(1, 1, 1, 1, 4'b1110));
    tick(1); hpLeftClr = 1'b1; tick(1); hpLeftClr = 1'b0;
    expectOut("R9 left headphone clear", mk(1, 1, 1, 1, 4'b1111));

    // R3: soft reset clears latches and restarts
    tick(1); ocFlag = 4'b0010; tick(1); ocFlag = 4'b0000;
    expectOut("R8 right headphone trip", mk(1, 1, 1, 1, 4'b1101));
    tick(1); softRst = 1'b1; tick(1); softRst = 1'b0;
    expectOut("R3 soft reset drops all", mk(0, 0, 0, 0, 4'b0000));
    tick(INIT_C - 1);
    expectOut("R3 one edge before ready", mk(0, 0, 0, 0, 4'b0000));
    tick(1);
    expectOut("R3 ready again, latches cleared", mk(1, 0, 1, 1, 4'b1111));
    tick(SETTLE_C - 1);
    expectOut("R6 settle after soft reset, not yet", mk(1, 0, 1, 1, 4'b1111));
    tick(1);
    expectOut("R6 settle after soft reset", mk(1, 1, 1, 1, 4'b1111));

    // R1: short glitch on the pin
    tick(1);
    rstPinN = 1'b0;
    #2;
    rstPinN = 1'b1;
    expectOut("R1 sub-cycle glitch resets", mk(0, 0, 0, 0, 4'b0000));
    tick(INIT_C + 1);
    expectOut("R2 after glitch, before ready", mk(0, 0, 0, 0, 4'b0000));
    tick(1);
    expectOut("R2 after glitch, ready", mk(1, 0, 1, 1, 4'b1111));

    done = 1'b1;
    summary();
    $finish;
  end
endmodule